// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register storage of a processor core that uses overlapping register windows. Each access names one of 32 architectural registers with a 5-bit number. The block turns that number into a physical index from the current window pointer and from a bank select for the globals. The physical file holds 64-bit words in three parts: a normal global bank of 8 registers, an alternate global bank of 8 registers, and a ring of window sets with 16 registers in each set. The number of sets, `NWIN`, can be 3 to 32.

Each set physically holds only its ins and its locals. The outs of the current window are the ins of the set one step below it on the ring. A save command moves the view down by one set, so the caller's outs become the callee's ins. A restore command moves the view back up. A mask register can mark any set as unavailable. A save or restore that would enter a marked set leaves the pointer where it is and sets a one-cycle overflow or underflow flag. The core uses these flags to start its own spill and fill handling.

Top module: `windowed_regfile`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask is all clear, and both overflow and underflow are low.
- R2: Architectural numbers map as follows: 0–7 are globals, 8–15 are outs, 16–23 are locals and 24–31 are ins. A value written through the write port on one clock edge can be read afterwards on either read port, and the two read ports select independently.
- R3: Register 0 always reads as zero on both read ports, whichever global bank is selected. Writes to register 0 are dropped, including a write in the same cycle as the read.
- R4: While `altSel` is 1, numbers 1–7 reach the alternate global bank. While it is 0 they reach the normal bank. The two banks hold separate values, and `altSel` has no effect on numbers 8–31.
- R5: A save moves the pointer from w to w−1 modulo `NWIN`, so 0 becomes `NWIN`−1. After the save, the new ins (24–31) return what the old outs (8–15) held.
- R6: A restore moves the pointer from w to w+1 modulo `NWIN`, so `NWIN`−1 becomes 0. After the restore, the outs return what the ins held before the restore.
- R7: A write in the same cycle as a save or restore uses the window pointer from before the move.
- R8: `maskWrEn` loads `maskWrData` into the invalid mask on a clock edge, and mask bit i marks set i. A save whose target set is marked keeps the pointer unchanged and raises `overflow` for exactly the one cycle after the command.
- R9: A restore whose target set is marked keeps the pointer unchanged and raises `underflow` for exactly the one cycle after the command.
- R10: When save and restore are asserted together, the save takes effect and the restore is ignored.
- R11: When a read port and the write port address the same physical register in the same cycle, the read port returns the new write data.
- R12: The ring wraps around. After `NWIN` saves in a row the pointer is back at its starting value, and the same locals are visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| altSel | input | 1 | Chooses the alternate global bank for numbers 1–7 |
| saveCmd | input | 1 | Move the window down one set |
| restoreCmd | input | 1 | Move the window up one set |
| maskWrEn | input | 1 | Load the invalid-window mask |
| maskWrData | input | NWIN | New mask value; bit i marks set i |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural number to write |
| wrData | input | DW | Write data |
| rdAddrA | input | 5 | Architectural number for read port A |
| rdDataA | output | DW | Read port A data (combinational) |
| rdAddrB | input | 5 | Architectural number for read port B |
| rdDataB | output | DW | Read port B data (combinational) |
| cwp | output | 5 | Current window pointer |
| overflow | output | 1 | A save was refused (one-cycle pulse) |
| underflow | output | 1 | A restore was refused (one-cycle pulse) |

## Verification
The pointer-step assertions assume that the command inputs are held low while reset is asserted. They also assume that every input is stable around each rising edge. The bench meets both conditions: it drives inputs one time unit after the edge and keeps all command lines at zero until reset is released. The bypass and zero-read properties sample the read address together with the write address, so the bench changes those addresses only between edges. The flag properties expect at most one command to win in a given cycle. The bench therefore exercises the case where save and restore arrive together on its own, with the mask clear.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  localparam int CWP_W  = 5;
  localparam int ARCH_W = 5;

  // View strobes from control to datapath
  typedef struct packed {
    logic [CWP_W-1:0] cwp;
    logic             altSel;
  } winView_t;
endpackage

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            altSel,
  input  logic            saveCmd,
  input  logic            restoreCmd,
  input  logic            maskWrEn,
  input  logic [NWIN-1:0] maskWrData,
  output winView_t        view,
  output logic            overflow,
  output logic            underflow
);
  localparam int IDXW = $clog2(NWIN);
  localparam logic [IDXW-1:0] LAST = IDXW'(NWIN - 1);

  logic [IDXW-1:0] cwpQ;
  logic [NWIN-1:0] maskQ;
  logic            ovfQ, unfQ;
  logic [IDXW-1:0] prevWin, nextWin;

  always_comb begin
    prevWin = (cwpQ == '0)  ? LAST : IDXW'(cwpQ - 1'b1);
    nextWin = (cwpQ == LAST) ? '0   : IDXW'(cwpQ + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwpQ  <= '0;
      maskQ <= '0;
      ovfQ  <= 1'b0;
      unfQ  <= 1'b0;
    end else begin
      ovfQ <= 1'b0;
      unfQ <= 1'b0;
      if (maskWrEn) maskQ <= maskWrData;
      if (saveCmd) begin
        if (maskQ[prevWin]) ovfQ <= 1'b1;
        else                cwpQ <= prevWin;
      end else if (restoreCmd) begin
        if (maskQ[nextWin]) unfQ <= 1'b1;
        else                cwpQ <= nextWin;
      end
    end
  end

  always_comb begin
    view.cwp    = CWP_W'(cwpQ);
    view.altSel = altSel;
  end
  assign overflow  = ovfQ;
  assign underflow = unfQ;

  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cwpQ <= LAST);  // R12
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> cwpQ == $past(cwpQ));  // R8
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> cwpQ == $past(cwpQ));  // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow));  // R10
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(saveCmd) && !overflow) |->
      cwpQ == (($past(cwpQ) == '0) ? LAST : IDXW'($past(cwpQ) - 1'b1)));  // R5
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(restoreCmd && !saveCmd) && !underflow) |->
      cwpQ == (($past(cwpQ) == LAST) ? '0 : IDXW'($past(cwpQ) + 1'b1)));  // R6
endmodule

// File: rtl/winrf_regs.sv
module winrf_regs
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  winView_t          view,
  input  logic              wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [ARCH_W-1:0] rdAddrA,
  input  logic [ARCH_W-1:0] rdAddrB,
  output logic [DW-1:0]     rdDataA,
  output logic [DW-1:0]     rdDataB
);
  localparam int IDXW  = $clog2(NWIN);
  localparam int NPHYS = 16 + 16 * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 2;
  localparam logic [IDXW-1:0] LAST = IDXW'(NWIN - 1);

  logic [DW-1:0]   mem [NPHYS];
  logic [IDXW-1:0] win;
  logic [PW-1:0]   wrPhys;
  logic            wrLive;

  assign win = IDXW'(view.cwp);

  // Sets start at 16; each set: ins at +0..7, locals at +8..15
  function automatic logic [PW-1:0] toPhys(input logic [ARCH_W-1:0] a,
                                           input logic [IDXW-1:0] w,
                                           input logic alt);
    logic [IDXW-1:0] below;
    int idx;
    below = (w == '0) ? LAST : IDXW'(w - 1'b1);
    case (a[4:3])
      2'b00:   idx = (alt ? 8 : 0) + int'(a[2:0]);
      2'b01:   idx = 16 + 16 * int'(below) + int'(a[2:0]);
      2'b10:   idx = 16 + 16 * int'(w) + 8 + int'(a[2:0]);
      default: idx = 16 + 16 * int'(w) + int'(a[2:0]);
    endcase
    return PW'(idx);
  endfunction

  assign wrPhys = toPhys(wrAddr, win, view.altSel);
  assign wrLive = wrEn && (wrAddr != '0);

  always_ff @(posedge clk) begin
    if (wrLive) mem[wrPhys] <= wrData;
  end

  logic [ARCH_W-1:0] rdAddr [NRD];
  logic [DW-1:0]     rdData [NRD];
  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [PW-1:0] rdPhys;
    assign rdPhys = toPhys(rdAddr[p], win, view.altSel);
    always_comb begin
      if (rdAddr[p] == '0)                   rdData[p] = '0;
      else if (wrLive && wrPhys == rdPhys)   rdData[p] = wrData;
      else                                   rdData[p] = mem[rdPhys];
    end
  end

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0));  // R3
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == '0) |-> (rdDataB == '0));  // R3
  AST_BYPASS_A: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && rdAddrA == wrAddr) |-> (rdDataA == wrData));  // R11
  AST_BYPASS_B: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0 && rdAddrB == wrAddr) |-> (rdDataB == wrData));  // R11
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              altSel,
  input  logic              saveCmd,
  input  logic              restoreCmd,
  input  logic              maskWrEn,
  input  logic [NWIN-1:0]   maskWrData,
  input  logic              wrEn,
  input  logic [ARCH_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [ARCH_W-1:0] rdAddrA,
  output logic [DW-1:0]     rdDataA,
  input  logic [ARCH_W-1:0] rdAddrB,
  output logic [DW-1:0]     rdDataB,
  output logic [CWP_W-1:0]  cwp,
  output logic              overflow,
  output logic              underflow
);
  winView_t view;

  winrf_ctrl #(.NWIN(NWIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .altSel(altSel), .saveCmd(saveCmd),
    .restoreCmd(restoreCmd), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .view(view), .overflow(overflow), .underflow(underflow)
  );

  winrf_regs #(.NWIN(NWIN), .DW(DW)) regs_i (
    .clk(clk), .rstN(rstN), .view(view), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  assign cwp = view.cwp;
endmodule

// File: tb/windowed_regfile_tb_top.sv
`timescale 1ns/100ps
module windowed_regfile_tb_top;
  localparam int NW = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic altSel = 1'b0, saveCmd = 1'b0, restoreCmd = 1'b0, maskWrEn = 1'b0;
  logic [NW-1:0] maskWrData = '0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic [4:0] cwp;
  logic overflow, underflow;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] localW;

  always #2.5 clk = ~clk;

  windowed_regfile #(.NWIN(NW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .altSel(altSel), .saveCmd(saveCmd),
    .restoreCmd(restoreCmd), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .cwp(cwp), .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [DW-1:0] val(int a, int tag);
    return {32'hC0DE0000 + 32'(tag), 32'(a)};
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic rdA(int a, output logic [DW-1:0] d);
    rdAddrA = 5'(a); #0.5; d = rdDataA;
  endtask

  task automatic rdB(int a, output logic [DW-1:0] d);
    rdAddrB = 5'(a); #0.5; d = rdDataB;
  endtask

  task automatic doCmd(logic s, logic r);
    saveCmd = s; restoreCmd = r;
    cyc();
    saveCmd = 1'b0; restoreCmd = 1'b0;
  endtask

  task automatic setMask(logic [NW-1:0] m);
    maskWrEn = 1'b1; maskWrData = m;
    cyc();
    maskWrEn = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 cwp", 64'(cwp), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    chk("R1 underflow", 64'(underflow), 64'd0);
  endtask

  task automatic testMapping();
    logic [DW-1:0] d;
    for (int a = 1; a < 32; a++) wr(a, val(a, 0));
    for (int a = 1; a < 32; a += 5) begin
      rdA(a, d); chk("R2 port A", d, val(a, 0));
    end
    rdA(9, d); rdB(26, d);
    chk("R2 port B", d, val(26, 0));
    rdA(9, d); chk("R2 port A independent", d, val(9, 0));
  endtask

  task automatic testZero();
    logic [DW-1:0] d;
    wr(0, 64'hDEAD);
    rdA(0, d); chk("R3 r0 port A", d, 64'd0);
    altSel = 1'b1;
    rdB(0, d); chk("R3 r0 port B alt", d, 64'd0);
    altSel = 1'b0;
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 64'hBEEF;
    rdA(0, d); chk("R3 r0 same-cycle write", d, 64'd0);
    cyc(); wrEn = 1'b0;
  endtask

  task automatic testAlt();
    logic [DW-1:0] d;
    altSel = 1'b1;
    wr(3, val(3, 9));
    rdA(17, d); chk("R4 window reg unaffected by alt", d, val(17, 0));
    rdA(3, d); chk("R4 alt bank value", d, val(3, 9));
    altSel = 1'b0;
    rdA(3, d); chk("R4 normal bank kept", d, val(3, 0));
  endtask

  task automatic testSaveRestore();
    logic [DW-1:0] d;
    doCmd(1'b1, 1'b0);
    chk("R5 save wraps 0 to NW-1", 64'(cwp), 64'(NW - 1));
    rdA(24, d); chk("R5 new ins = old outs", d, val(8, 0));
    rdB(31, d); chk("R5 new ins = old outs", d, val(15, 0));
    wr(16, val(16, 7));
    wr(24, val(24, 7));
    doCmd(1'b0, 1'b1);
    chk("R6 restore wraps NW-1 to 0", 64'(cwp), 64'd0);
    rdA(8, d); chk("R6 outs = prior ins", d, val(24, 7));
    rdA(16, d); chk("R6 locals of window 0 kept", d, val(16, 0));
    rdA(24, d); chk("R6 ins of window 0 kept", d, val(24, 0));
  endtask

  task automatic testWriteOldPtr();
    logic [DW-1:0] d;
    localW = val(16, 5);
    saveCmd = 1'b1; wrEn = 1'b1; wrAddr = 5'd16; wrData = localW;
    cyc();
    saveCmd = 1'b0; wrEn = 1'b0;
    rdA(16, d); chk("R7 new window local untouched", d, val(16, 7));
    doCmd(1'b0, 1'b1);
    rdA(16, d); chk("R7 write used old pointer", d, localW);
  endtask

  task automatic testWrap();
    logic [DW-1:0] d;
    for (int i = 1; i <= NW; i++) begin
      doCmd(1'b1, 1'b0);
      chk("R12 pointer during wrap", 64'(cwp), 64'((NW - i) % NW));
    end
    rdA(16, d); chk("R12 locals visible again", d, localW);
  endtask

  task automatic testOverflow();
    setMask(NW'(1) << (NW - 1));
    doCmd(1'b1, 1'b0);
    chk("R8 overflow raised", 64'(overflow), 64'd1);
    chk("R8 cwp held", 64'(cwp), 64'd0);
    cyc();
    chk("R8 overflow one cycle", 64'(overflow), 64'd0);
  endtask

  task automatic testUnderflow();
    setMask(NW'(2));
    doCmd(1'b0, 1'b1);
    chk("R9 underflow raised", 64'(underflow), 64'd1);
    chk("R9 cwp held", 64'(cwp), 64'd0);
    cyc();
    chk("R9 underflow one cycle", 64'(underflow), 64'd0);
  endtask

  task automatic testBoth();
    setMask('0);
    doCmd(1'b1, 1'b1);
    chk("R10 save wins", 64'(cwp), 64'(NW - 1));
    chk("R10 no flags", 64'({overflow, underflow}), 64'd0);
    doCmd(1'b0, 1'b1);
    chk("R10 back to 0", 64'(cwp), 64'd0);
  endtask

  task automatic testBypass();
    logic [DW-1:0] d;
    wrEn = 1'b1; wrAddr = 5'd20; wrData = 64'h1234_5678_9ABC_DEF0;
    rdB(20, d); chk("R11 bypass port B", d, 64'h1234_5678_9ABC_DEF0);
    rdA(20, d); chk("R11 bypass port A", d, 64'h1234_5678_9ABC_DEF0);
    cyc(); wrEn = 1'b0;
    rdA(20, d); chk("R11 value stored", d, 64'h1234_5678_9ABC_DEF0);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    testReset();
    testMapping();
    testZero();
    testAlt();
    testSaveRestore();
    testWriteOldPtr();
    testWrap();
    testOverflow();
    testUnderflow();
    testBoth();
    testBypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule